// File: doc/BRIEF.md
# Single-channel APB down-counting timer

The block is a 32-bit down-counter behind a zero-wait-state APB slave port. Software places a reload value in a load register, sets control bits for run, reload style and interrupt masking, and may read the live count at any time. Each time the count passes through zero, the counter reloads and a raw interrupt flag is set. The flag stays set until software reads one of the two clear registers.

Two reload styles are offered. Periodic mode reloads the programmed value, so an event occurs every load+1 timer clocks. Free-running mode always reloads all ones and disregards the load register, so the inverted count is a continuous up-counting time base over the full 32-bit range. A masked copy of the flag drives the interrupt output. Reading the masked status gives the same view, and a raw status register shows the flag whatever the mask. A version register returns a fixed constant.

Top module: `apb_dtimer`

## Requirements
- R1: After reset all registers read zero except the version register, the counter is 0 and stopped, and irq_o is low.
- R2: pready_o is always 1 and pslverr_o always 0. Reads return their value in the access cycle, and control (offset 0x08) reads back the written bits [2:0] with all upper bits zero. The bit layout is bit0 run, bit1 periodic, bit2 mask.
- R3: A write to the load register (offset 0x00) is ignored while the run bit is 1.
- R4: A control write that changes the run bit from 0 to 1 loads the counter from the load register at that write's clock edge. While the run bit is 0, the counter holds its value.
- R5: While running, the counter decrements once per clock. On the clock after it reads 0, periodic mode reloads the load value and sets the raw flag.
- R6: In free-running mode (bit1=0) the counter reloads 0xFFFFFFFF on expiry, whatever the load register holds, and the raw flag is set.
- R7: The interrupt status registers at 0x10 and 0xA0 return in bit 0 the raw flag AND NOT the mask bit, and irq_o equals that value. The raw status register at 0xA8 returns the flag regardless of the mask.
- R8: A read of 0x0C or 0xA4 returns 0 and clears the raw flag.
- R9: If an expiry falls on the same clock edge as a clear read, the flag stays set.
- R10: Writing 0 to control stops the counter, which then holds its value, and removes the mask, so a pending flag then drives irq_o high.
- R11: The version register at 0xAC returns the VERSION parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| irq_o | output | 1 | Masked timer interrupt |

## Verification
An expiry and a clear read can fall on the same clock edge. In that case the new event must win over the clear. The bench runs the counter in periodic mode with a known load value and counts clocks from the enabling write. It then issues a clear read whose access edge is exactly the second reload edge. Afterwards the raw status must still read 1. A later clear read that falls between expiries must leave it at 0.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int DATA_W = 32;

  // byte offsets decoded by software drivers
  localparam int OFF_LD   = 'h00;
  localparam int OFF_CUR  = 'h04;
  localparam int OFF_CTL  = 'h08;
  localparam int OFF_CLR  = 'h0C;
  localparam int OFF_IST  = 'h10;
  localparam int OFF_GIST = 'hA0;
  localparam int OFF_GCLR = 'hA4;
  localparam int OFF_GRAW = 'hA8;
  localparam int OFF_VER  = 'hAC;

  typedef struct packed {
    logic msk;  // bit2: 1 masks the interrupt
    logic per;  // bit1: 1 periodic, 0 free-running
    logic en;   // bit0: run
  } ctl_t;
endpackage

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int              CNT_W   = 32,
  parameter int              ADDR_W  = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  input  logic              irq_i,
  output ctl_t              ctl_o,
  output logic [CNT_W-1:0]  ld_o,
  output logic              start_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] prdata_o
);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t             ctl_q;
  logic [CNT_W-1:0] ld_q;
  logic             wr_acc, rd_acc;
  logic             sel_ld, sel_ctl, sel_clr, sel_gclr;

  assign wr_acc   = psel_i && penable_i && pwrite_i;
  assign rd_acc   = psel_i && penable_i && !pwrite_i;
  assign sel_ld   = paddr_i == ADDR_W'(OFF_LD);
  assign sel_ctl  = paddr_i == ADDR_W'(OFF_CTL);
  assign sel_clr  = paddr_i == ADDR_W'(OFF_CLR);
  assign sel_gclr = paddr_i == ADDR_W'(OFF_GCLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      ld_q  <= '0;
    end else begin
      if (wr_acc && sel_ctl) ctl_q <= ctl_t'(pwdata_i[CTL_W-1:0]);
      if (wr_acc && sel_ld && !ctl_q.en) ld_q <= pwdata_i[CNT_W-1:0];
    end
  end

  // run bit rising: counter takes the load value on this same edge
  assign start_o = wr_acc && sel_ctl && pwdata_i[0] && !ctl_q.en;
  assign clr_o   = rd_acc && (sel_clr || sel_gclr);
  assign ctl_o   = ctl_q;
  assign ld_o    = ld_q;

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      ADDR_W'(OFF_LD):   prdata_o = DATA_W'(ld_q);
      ADDR_W'(OFF_CUR):  prdata_o = DATA_W'(cnt_i);
      ADDR_W'(OFF_CTL):  prdata_o = DATA_W'(ctl_q);
      ADDR_W'(OFF_IST),
      ADDR_W'(OFF_GIST): prdata_o = DATA_W'(irq_i);
      ADDR_W'(OFF_GRAW): prdata_o = DATA_W'(raw_i);
      ADDR_W'(OFF_VER):  prdata_o = VERSION;
      default:           prdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dtimer_core.sv
module dtimer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             per_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] ld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] FREE_RELOAD = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload   = per_i ? ld_i : FREE_RELOAD;
  assign expire_o = en_i && !start_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (start_i)   cnt_q <= ld_i;
    else if (expire_o)  cnt_q <= reload;
    else if (en_i)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic raw_o,
  output logic irq_o
);
  logic raw_q;

  // a new event beats a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       raw_q <= 1'b0;
    else if (expire_i) raw_q <= 1'b1;
    else if (clr_i)    raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q && !mask_i;
endmodule

// File: rtl/apb_dtimer.sv
module apb_dtimer
  import dtimer_pkg::*;
#(
  parameter int                CNT_W   = 32,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              irq_o
);
  ctl_t             ctl;
  logic             ctl_en, ctl_per, ctl_msk;
  logic [CNT_W-1:0] ld_q, cnt_q;
  logic             start, clr, expire, raw;

  assign ctl_en  = ctl.en;
  assign ctl_per = ctl.per;
  assign ctl_msk = ctl.msk;

  dtimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .cnt_i(cnt_q), .raw_i(raw), .irq_i(irq_o),
    .ctl_o(ctl), .ld_o(ld_q), .start_o(start), .clr_o(clr), .prdata_o(prdata_o)
  );

  dtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .en_i(ctl_en), .per_i(ctl_per), .start_i(start),
    .ld_i(ld_q), .cnt_o(cnt_q), .expire_o(expire)
  );

  dtimer_irq u_irq (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(clr), .mask_i(ctl_msk),
    .raw_o(raw), .irq_o(irq_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk
  import dtimer_pkg::*;
#(
  parameter int                CNT_W   = 32,
  parameter int                ADDR_W  = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       prdata_i,
  input logic              pready_i,
  input logic              pslverr_i,
  input logic              irq_i,
  input logic              en_i,
  input logic              per_i,
  input logic              start_i,
  input logic              clr_i,
  input logic              raw_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  ld_i
);
  logic wr_acc, rd_acc, hit;
  assign wr_acc = psel_i && penable_i && pwrite_i;
  assign rd_acc = psel_i && penable_i && !pwrite_i;
  assign hit    = en_i && !start_i && (cnt_i == '0);

  assert_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_i && !pslverr_i);

  assert_ld_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && paddr_i == ADDR_W'(OFF_LD) && en_i) |=> $stable(ld_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(cnt_i));

  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_i == $past(ld_i));

  assert_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && cnt_i != '0) |=> cnt_i == CNT_W'($past(cnt_i) - 1'b1));

  assert_per_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && per_i) |=> (cnt_i == $past(ld_i)) && raw_i);

  assert_free_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !per_i) |=> (cnt_i == '1) && raw_i);

  assert_stat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && (paddr_i == ADDR_W'(OFF_GIST) || paddr_i == ADDR_W'(OFF_IST)))
      |-> prdata_i[0] == irq_i);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !raw_i);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> raw_i);

  assert_version_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == ADDR_W'(OFF_VER)) |-> prdata_i == VERSION);
endmodule

bind apb_dtimer dtimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .paddr_i(paddr_i), .prdata_i(prdata_o),
  .pready_i(pready_o), .pslverr_i(pslverr_o), .irq_i(irq_o),
  .en_i(ctl_en), .per_i(ctl_per), .start_i(start), .clr_i(clr),
  .raw_i(raw), .cnt_i(cnt_q), .ld_i(ld_q)
);

// File: tb/apb_dtimer_bench.sv
module apb_dtimer_bench;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;

  int unsigned cyc = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  int unsigned kp;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  apb_dtimer #(.VERSION(VER)) u_apb_dtimer (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d,
                        output int unsigned k);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); k = cyc;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d,
                        output int unsigned c);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1; d = prdata; c = cyc;
    chk("R2", "pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_until(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_per(input int unsigned l, input int unsigned j);
    return 32'(l - (j % (l + 1)));
  endfunction

  function automatic logic [31:0] exp_free(input int unsigned l, input int unsigned j);
    if (j <= l) return 32'(l - j);
    return 32'hFFFF_FFFF - 32'(j - l - 1);
  endfunction

  task automatic t_reset();
    logic [31:0] d; int unsigned c;
    chk("R1", "irq after reset", {31'd0, irq}, 32'h0);
    foreach (d[i]) begin end
    apb_rd(8'h00, d, c); chk("R1", "load", d, 0);
    apb_rd(8'h04, d, c); chk("R1", "count", d, 0);
    apb_rd(8'h08, d, c); chk("R1", "control", d, 0);
    apb_rd(8'hA8, d, c); chk("R1", "raw", d, 0);
    apb_rd(8'hA0, d, c); chk("R1", "status", d, 0);
    apb_rd(8'hAC, d, c); chk("R11", "version", d, VER);
  endtask

  task automatic t_regs();
    logic [31:0] d; int unsigned c, k;
    apb_wr(8'h00, 32'h1234_5678, k);
    apb_rd(8'h00, d, c); chk("R2", "load readback", d, 32'h1234_5678);
    apb_wr(8'h08, 32'hFFFF_FFF6, k);
    apb_rd(8'h08, d, c); chk("R2", "control readback", d, 32'h6);
    wait_until(cyc + 4);
    apb_rd(8'h04, d, c); chk("R4", "stopped count holds", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d; int unsigned c;
    apb_wr(8'h00, 32'd40, kp);
    apb_wr(8'h08, 32'h3, kp);
    apb_rd(8'h04, d, c); chk("R4", "start loads", d, exp_per(40, c - kp));
    wait_until(cyc + 7);
    apb_rd(8'h04, d, c); chk("R5", "decrement", d, exp_per(40, c - kp));
    wait_until(kp + 45);
    chk("R5", "irq after expiry", {31'd0, irq}, 32'h1);
    apb_rd(8'hA8, d, c); chk("R5", "raw after expiry", d, 1);
    apb_rd(8'h10, d, c); chk("R7", "local status", d, 1);
    apb_rd(8'hA0, d, c); chk("R7", "global status", d, 1);
    apb_rd(8'h04, d, c); chk("R5", "periodic reload", d, exp_per(40, c - kp));
    apb_rd(8'h0C, d, c); chk("R8", "clear reads zero", d, 0);
    apb_rd(8'hA8, d, c); chk("R8", "raw cleared", d, 0);
    chk("R8", "irq cleared", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d, v1; int unsigned c, k;
    apb_wr(8'h08, 32'h7, k);
    apb_wr(8'h00, 32'h77, k);
    wait_until(kp + 84);
    chk("R7", "masked irq low", {31'd0, irq}, 32'h0);
    apb_rd(8'h10, d, c); chk("R7", "masked local status", d, 0);
    apb_rd(8'hA0, d, c); chk("R7", "masked global status", d, 0);
    apb_rd(8'hA8, d, c); chk("R7", "raw under mask", d, 1);
    apb_rd(8'h00, d, c); chk("R3", "load kept while running", d, 32'd40);
    apb_wr(8'h08, 32'h0, k);
    apb_rd(8'h08, d, c); chk("R10", "control zero", d, 0);
    chk("R10", "unmasked irq", {31'd0, irq}, 32'h1);
    apb_rd(8'h04, v1, c);
    wait_until(cyc + 5);
    apb_rd(8'h04, d, c); chk("R10", "stop holds count", d, v1);
    apb_wr(8'h08, 32'h3, k);
    apb_rd(8'h04, d, c); chk("R3", "restart uses old load", d, exp_per(40, c - k));
  endtask

  task automatic t_free();
    logic [31:0] d; int unsigned c, k;
    apb_wr(8'h08, 32'h0, k);
    apb_rd(8'h0C, d, c);
    apb_wr(8'h00, 32'd5, k);
    apb_wr(8'h08, 32'h1, k);
    wait_until(k + 10);
    apb_rd(8'h04, d, c); chk("R6", "free wrap", d, exp_free(5, c - k));
    apb_rd(8'hA8, d, c); chk("R6", "raw on free expiry", d, 1);
    apb_rd(8'h04, d, c); chk("R6", "free keeps counting", d, exp_free(5, c - k));
    apb_rd(8'h00, d, c); chk("R6", "load untouched", d, 5);
  endtask

  task automatic t_gclr();
    logic [31:0] d; int unsigned c;
    apb_rd(8'hA4, d, c); chk("R8", "global clear reads zero", d, 0);
    apb_rd(8'hA8, d, c); chk("R8", "raw after global clear", d, 0);
    chk("R8", "irq after global clear", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d; int unsigned c, k;
    apb_wr(8'h08, 32'h0, k);
    apb_wr(8'h00, 32'd20, k);
    apb_wr(8'h08, 32'h3, k);
    wait_until(k + 40);
    apb_rd(8'h0C, d, c);  // access edge k+42 = second expiry
    apb_rd(8'hA8, d, c); chk("R9", "set wins over clear", d, 1);
    chk("R9", "irq stays", {31'd0, irq}, 32'h1);
    apb_rd(8'h0C, d, c);
    apb_rd(8'hA8, d, c); chk("R8", "clear between expiries", d, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_periodic();
    t_mask();
    t_free();
    t_gclr();
    t_collide();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule